// File: doc/BRIEF.md
# Shaped On/Off Keying Amplitude Shaper

This block sits in front of a pair of in-phase and quadrature sample streams. It multiplies both 12-bit two's-complement samples by a 12-bit unsigned amplitude factor, so that a burst fades in and fades out rather than starting or stopping abruptly. In automatic mode the factor is a 12-bit envelope counter. The counter steps toward full scale while the keying input is high and toward zero while it is low. Its step rate comes from an 8-bit programmable prescaler.

Three other ways of using the block are selected by configuration inputs. In manual mode each channel takes its factor from its own 12-bit register, so software can shape the envelope in any way it likes. A bypass setting passes both samples through unchanged. On the Q channel only, a 12-bit two's-complement word can replace the sample completely. Both outputs are registered, with one clock of latency.

Top module: `okey_shaper`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become 0, the envelope becomes 0 and the prescaler count becomes 0.
- R2: The prescaler runs at all times after reset and produces a step in the first cycle after reset and then one every N+1 cycles, where N is `ramp_rate` read when the count is reloaded; a `ramp_rate` of 0 behaves as 1.
- R3: In automatic mode, a step while `key` is high raises the envelope by one, and the envelope holds at 4095 once it gets there.
- R4: In automatic mode, a step while `key` is low lowers the envelope by one, and the envelope holds at 0 once it gets there; a change of `key` during a ramp turns the ramp around from the present envelope value.
- R5: A factor A below 4095 gives the output floor((x*A + 2048) / 4096) for sample x, so A = 0 gives 0.
- R6: A factor of 4095 is unity gain: the output equals the sample.
- R7: With `shape_en` low, both samples pass through unchanged and the envelope holds its value.
- R8: With `shape_en` high and `auto_sel` low, the I factor is `man_i` and the Q factor is `man_q`, set independently; the envelope holds, and it resumes from the held value when automatic mode returns.
- R9: With `q_alt_sel` high, `q_out` equals `q_alt_word` unscaled, whatever the other settings are; the I path is unaffected.
- R10: Each output reflects the inputs and the envelope value present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i_in | input | 12 | In-phase sample, two's complement |
| q_in | input | 12 | Quadrature sample, two's complement |
| key | input | 1 | Keying level: 1 ramps up, 0 ramps down |
| shape_en | input | 1 | 1 enables scaling, 0 bypasses it |
| auto_sel | input | 1 | 1 uses the envelope counter, 0 uses the manual factors |
| q_alt_sel | input | 1 | 1 replaces the Q output with `q_alt_word` |
| ramp_rate | input | 8 | Prescaler reload value N (step period N+1) |
| man_i | input | 12 | Manual I factor, unsigned |
| man_q | input | 12 | Manual Q factor, unsigned |
| q_alt_word | input | 12 | Replacement Q word, two's complement |
| i_out | output | 12 | Scaled in-phase sample, registered |
| q_out | output | 12 | Scaled or replaced quadrature sample, registered |

## Verification
The envelope and the prescaler count are hidden. A wrong value in either shows up only through the scaled outputs, and only while automatic mode is active and the samples are not zero. An envelope that is off by one step changes the outputs by about one part in 4096 of full-scale input. It appears in the next cycle that has a large sample. A prescaler phase error moves every later envelope step, so the error shows within one step period of the fault. State that is corrupted while bypass or manual mode is selected stays hidden until automatic mode comes back. That is why the stimulus returns to automatic mode after each of those phases and drives random full-range samples on every cycle.

// File: rtl/okey_pkg.sv
package okey_pkg;

    localparam int SMP_W  = 12;
    localparam int AMP_W  = 12;
    localparam int RATE_W = 8;
    localparam int CH_N   = 2;
    localparam int CH_I   = 0;
    localparam int CH_Q   = 1;
    localparam int PROD_W = SMP_W + AMP_W + 2;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic        [AMP_W-1:0]  amp_t;
    typedef logic        [RATE_W-1:0] rate_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    localparam amp_t  AMP_MAX  = '1;
    localparam amp_t  AMP_ZERO = '0;
    localparam prod_t HALF_LSB = prod_t'(1) <<< (AMP_W - 1);

    typedef enum logic [1:0] {
        GAIN_BYPASS = 2'd0,
        GAIN_RAMP   = 2'd1,
        GAIN_MANUAL = 2'd2
    } gain_src_e;

    typedef struct packed {
        logic  enable;
        logic  automatic_on;
        logic  q_replace;
    } shape_cfg_t;

    function automatic gain_src_e pick_source(shape_cfg_t cfg);
        if (!cfg.enable)       return GAIN_BYPASS;
        if (cfg.automatic_on)  return GAIN_RAMP;
        return GAIN_MANUAL;
    endfunction

    function automatic rate_t effective_rate(rate_t r);
        return (r == '0) ? rate_t'(1) : r;
    endfunction

    // Full-ones factor is unity; others are rounded x*a/2^AMP_W.
    function automatic smp_t amp_apply(smp_t x, amp_t a);
        prod_t prod;
        prod_t rnd;
        if (a == AMP_MAX) return x;
        prod = prod_t'(x) * prod_t'($signed({1'b0, a}));
        rnd  = (prod + HALF_LSB) >>> AMP_W;
        return smp_t'(rnd);
    endfunction

endpackage

// File: rtl/okey_rate_div.sv
module okey_rate_div
    import okey_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] rate,
    output logic          step
);
    logic [RW-1:0] cnt;
    logic [RW-1:0] reload;

    assign reload = (rate == '0) ? RW'(1) : rate;
    assign step   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= reload;
        else           cnt <= cnt - RW'(1);
    end

    // R2
    step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/okey_envelope.sv
module okey_envelope
    import okey_pkg::*;
#(
    parameter int AW = AMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          run,
    input  logic          key,
    output logic [AW-1:0] amp
);
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] BOT = '0;

    logic          advance;
    logic [AW-1:0] amp_next;

    assign advance = step && run;

    always_comb begin
        amp_next = amp;
        if (advance) begin
            if (key && amp != TOP)       amp_next = amp + AW'(1);
            else if (!key && amp != BOT) amp_next = amp - AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) amp <= BOT;
        else     amp <= amp_next;
    end

    // R3
    env_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (step && run && key && amp != TOP) |=> amp == $past(amp) + AW'(1));
    // R3
    env_top_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (amp == TOP && key) |=> amp == TOP);
    // R4
    env_floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (amp == BOT && !key) |=> amp == BOT);
    // R7
    env_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(step && run) |=> $stable(amp));

endmodule

// File: rtl/okey_shaper.sv
module okey_shaper
    import okey_pkg::*;
#(
    parameter bit Q_ALT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] i_in,
    input  logic [SMP_W-1:0] q_in,
    input  logic             key,
    input  logic             shape_en,
    input  logic             auto_sel,
    input  logic             q_alt_sel,
    input  logic [RATE_W-1:0] ramp_rate,
    input  logic [AMP_W-1:0] man_i,
    input  logic [AMP_W-1:0] man_q,
    input  logic [SMP_W-1:0] q_alt_word,
    output logic [SMP_W-1:0] i_out,
    output logic [SMP_W-1:0] q_out
);
    shape_cfg_t cfg;
    gain_src_e  src;
    logic       step;
    amp_t       env_amp;
    smp_t       samp_in [CH_N];
    amp_t       man_fac [CH_N];

    assign cfg.enable       = shape_en;
    assign cfg.automatic_on = auto_sel;
    assign cfg.q_replace    = q_alt_sel;
    assign src              = pick_source(cfg);

    assign samp_in[CH_I] = smp_t'(i_in);
    assign samp_in[CH_Q] = smp_t'(q_in);
    assign man_fac[CH_I] = man_i;
    assign man_fac[CH_Q] = man_q;

    okey_rate_div #(.RW(RATE_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .rate (ramp_rate),
        .step (step)
    );

    okey_envelope #(.AW(AMP_W)) u_env (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .run  (src == GAIN_RAMP),
        .key  (key),
        .amp  (env_amp)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        amp_t fac;
        smp_t scaled;
        smp_t picked;
        smp_t out_r;

        assign fac    = (src == GAIN_MANUAL) ? man_fac[c] : env_amp;
        assign scaled = (src == GAIN_BYPASS) ? samp_in[c] : amp_apply(samp_in[c], fac);

        if (c == CH_Q && Q_ALT_EN) begin : g_alt
            assign picked = cfg.q_replace ? smp_t'(q_alt_word) : scaled;
        end else begin : g_plain
            assign picked = scaled;
        end

        always_ff @(posedge clk) begin
            if (rst) out_r <= '0;
            else     out_r <= picked;
        end
    end

    assign i_out = g_ch[CH_I].out_r;
    assign q_out = g_ch[CH_Q].out_r;

    // R7
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!shape_en && !q_alt_sel) |=> q_out == $past(q_in));
    // R9
    q_replace_chk: assert property (@(posedge clk) disable iff (rst)
        q_alt_sel |=> q_out == $past(q_alt_word));
    // R6
    unity_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (shape_en && auto_sel && env_amp == AMP_MAX) |=> i_out == $past(i_in));
    // R5
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (shape_en && !auto_sel && man_i == AMP_ZERO) |=> i_out == '0);

endmodule

// File: tb/tb_okey_shaper.sv
module tb_okey_shaper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] i_in = '0, q_in = '0;
    logic        key = 1'b0, shape_en = 1'b0, auto_sel = 1'b0, q_alt_sel = 1'b0;
    logic [7:0]  ramp_rate = '0;
    logic [11:0] man_i = '0, man_q = '0, q_alt_word = '0;
    logic [11:0] i_out, q_out;

    always #10 clk = ~clk;

    okey_shaper dut (
        .clk(clk), .rst(rst), .i_in(i_in), .q_in(q_in), .key(key),
        .shape_en(shape_en), .auto_sel(auto_sel), .q_alt_sel(q_alt_sel),
        .ramp_rate(ramp_rate), .man_i(man_i), .man_q(man_q),
        .q_alt_word(q_alt_word), .i_out(i_out), .q_out(q_out)
    );

    int    n_cmp = 0, n_bad = 0;
    int    m_env = 0, m_cnt = 0, e_i = 0, e_q = 0;
    bit    e_valid = 1'b0, done = 1'b0, rand_fac = 1'b0;
    string tag = "R1";

    function automatic int sv12(logic [11:0] v);
        return int'($signed(v));
    endfunction

    function automatic int gain(int x, int a);
        if (a == 4095) return x;
        return (x * a + 2048) >>> 12;
    endfunction

    task automatic chk(string r, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int  fi, fq, xi, xq;
        bit  tick;
        if (rst) begin
            e_i = 0; e_q = 0; m_env = 0; m_cnt = 0;
        end else begin
            tick = (m_cnt == 0);
            xi = sv12(i_in); xq = sv12(q_in);
            fi = auto_sel ? m_env : int'(man_i);
            fq = auto_sel ? m_env : int'(man_q);
            e_i = shape_en ? gain(xi, fi) : xi;
            e_q = q_alt_sel ? sv12(q_alt_word) : (shape_en ? gain(xq, fq) : xq);
            if (tick) m_cnt = (ramp_rate == 0) ? 1 : int'(ramp_rate);
            else      m_cnt = m_cnt - 1;
            if (tick && shape_en && auto_sel) begin
                if (key && m_env < 4095) m_env++;
                else if (!key && m_env > 0) m_env--;
            end
        end
        e_valid = 1'b1;
    end

    always @(negedge clk) begin
        if (e_valid && !done) begin
            chk(tag, "i_out", sv12(i_out), e_i);
            chk(tag, "q_out", sv12(q_out), e_q);
        end
    end

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            i_in = 12'($urandom);
            q_in = 12'($urandom);
            if (k % 7 == 0) begin i_in = 12'h800; q_in = 12'h7FF; end
            if (rand_fac) begin man_i = 12'($urandom); man_q = 12'($urandom); end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (4) @(negedge clk);
        chk("R1", "i_out reset", sv12(i_out), 0);
        chk("R1", "q_out reset", sv12(q_out), 0);
        rst = 1'b0;
        // R7 and R10: bypass, envelope must not move while key is high
        tag = "R7/R10"; key = 1'b1; run(300);
        // R2, R3, R6: rate 0 behaves as 1, full ramp up and saturation
        tag = "R3/R6"; shape_en = 1'b1; auto_sel = 1'b1; ramp_rate = 8'd0;
        run(8400);
        // R4: ramp down, reverse mid-ramp, then down to floor
        tag = "R4"; key = 1'b0; run(1000);
        key = 1'b1; run(600);
        key = 1'b0; ramp_rate = 8'd3; run(16500);
        // R2: slow rate and a rate change while running
        tag = "R2"; key = 1'b1; ramp_rate = 8'd255; run(3000);
        ramp_rate = 8'd5; run(500);
        // R8: manual factors, envelope holds, then resumes
        tag = "R8"; auto_sel = 1'b0;
        man_i = 12'd0;    man_q = 12'd4095; run(200);
        key = 1'b0;
        man_i = 12'd2048; man_q = 12'd1;    run(200);
        man_i = 12'd4095; man_q = 12'd0;    run(200);
        key = 1'b1; auto_sel = 1'b1; run(300);
        // R9: replacement word on Q in every mode
        tag = "R9"; q_alt_sel = 1'b1; q_alt_word = 12'h800; run(100);
        shape_en = 1'b0; q_alt_word = 12'h7FF; run(100);
        shape_en = 1'b1; auto_sel = 1'b0; q_alt_word = 12'h123; run(100);
        q_alt_sel = 1'b0;
        // R5: random manual factors each cycle
        tag = "R5"; rand_fac = 1'b1; run(2000);
        rand_fac = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule